// File: doc/BRIEF.md
# DMA Controller Register Port

This block is the processor-facing register file of a four-channel DMA controller. A host on an 8-bit data bus selects it with a chip select. It picks one of sixteen locations with a 4-bit offset and issues single-cycle read or write strobes. Each channel has a 16-bit memory address and a 16-bit transfer count, and each is kept as a base copy and a current copy. The host moves these values one byte per access. An internal byte-pointer flip-flop decides whether an access reaches the low byte or the high byte.

Several offsets do not hold storage. A write or read there acts as a command: it re-arms the byte pointer, clears the whole controller, opens all channel masks, or rewinds the mode-readback counter. The per-channel mode registers all share one offset. Successive reads from that offset walk through the channels. The command byte, the mask bits, the software request bits and the stored modes are driven out to the transfer engine, which sits outside this block. That engine reports terminal counts back through a pulse input.

Top module: `dmac_regport`

## Requirements
- R1: After reset: mask output 4'b1111, command output 0, software request output 0, all modes 0, status reads 0, current address and count read 0, byte pointer on the low byte, mode-readback counter 0.
- R2: Offset 2*ch accesses channel ch's address and offset 2*ch+1 its count (ch 0..3). Every read or write at offsets 0..7 reaches the low byte when the byte pointer is clear and the high byte when it is set, then toggles the pointer.
- R3: A write at offsets 0..7 loads the addressed byte into both the base and the current register; reads at offsets 0..7 return the current register.
- R4: A write at offset 12 clears the byte pointer (next access hits the low byte); a read at offset 12 sets it (next access hits the high byte) and returns 0.
- R5: A write at offset 13 clears the command, software requests, terminal-count flags, byte pointer and mode-readback counter, and sets all four mask bits; address, count and mode registers keep their values.
- R6: A write at offset 14 clears all mask bits. A write at offset 15 loads the mask from data bits 3:0. A write at offset 10 selects a channel with data bits 1:0 and sets its mask bit when data bit 2 is 1, or clears it when data bit 2 is 0.
- R7: A write at offset 9 selects a channel with data bits 1:0 and sets (data bit 2 = 1) or clears (0) its software request bit, which appears on the request output.
- R8: A read at offset 8 returns terminal-count flags in bits 3:0 and pending requests (software request OR hardware request) in bits 7:4. The read clears the flags. A terminal-count pulse arriving in the same cycle as the read survives it.
- R9: A write at offset 11 stores data bits 7:2 as the mode of the channel selected by data bits 1:0; these six bits per channel appear on the mode output.
- R10: A read at offset 11 returns {mode[k], 2'b11}, where k is the readback counter. k advances on each such read, from channel 0 up to 3 and then back to 0. A read at offset 14 resets k to 0.
- R11: A write at offset 8 loads the command output with the full data byte.
- R12: Reads at offsets 9, 10, 13 and 15 return 0. With chip select low, strobes have no effect and the data output stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs | input | 1 | Chip select, active high |
| wr | input | 1 | Write strobe, one cycle per access |
| rd | input | 1 | Read strobe, one cycle per access; a write wins if both are high |
| addr | input | 4 | Register offset |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, valid during the read cycle, 0 otherwise |
| tc_set | input | 4 | Terminal-count pulse per channel from the transfer engine |
| dreq | input | 4 | Hardware request level per channel |
| cmd_q | output | 8 | Command byte |
| mask_q | output | 4 | Channel mask bits |
| swreq_q | output | 4 | Software request bits |
| chan_mode | output | 24 | Six mode bits per channel, channel 0 in bits 5:0 |

## Verification
The hardest state to reach is the byte pointer sitting on the high byte at the instant a command or clear lands. Reads and writes are both counted, so the phase depends on the whole history of accesses at offsets 0..7. The stimulus leaves the pointer deliberately odd before the master clear and before the pointer-set read. It then reads a known address back to prove which byte comes out. A second hard case is a terminal-count pulse that coincides with the clearing status read. The bench holds the pulse across the read, releases it, and reads again to show that the flag survived.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int NCH = 4;
  localparam int CHW = $clog2(NCH);
  localparam int DW  = 8;
  localparam int RW  = 2 * DW;
  localparam int MW  = DW - 2;

  localparam logic [3:0] A_CMD   = 4'd8;
  localparam logic [3:0] A_REQ   = 4'd9;
  localparam logic [3:0] A_SMASK = 4'd10;
  localparam logic [3:0] A_MODE  = 4'd11;
  localparam logic [3:0] A_FF    = 4'd12;
  localparam logic [3:0] A_MCLR  = 4'd13;
  localparam logic [3:0] A_CMASK = 4'd14;
  localparam logic [3:0] A_AMASK = 4'd15;

  // Replace one byte of a 16-bit register, chosen by the byte pointer.
  function automatic logic [RW-1:0] put_byte(input logic [RW-1:0] old,
                                             input logic hi,
                                             input logic [DW-1:0] b);
    return hi ? {b, old[DW-1:0]} : {old[RW-1:DW], b};
  endfunction

  function automatic logic [DW-1:0] get_byte(input logic [RW-1:0] v,
                                             input logic hi);
    return hi ? v[RW-1:DW] : v[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] mode_view(input logic [MW-1:0] m);
    return {m, 2'b11};
  endfunction

  function automatic logic [DW-1:0] status_byte(input logic [NCH-1:0] pend,
                                                input logic [NCH-1:0] tc);
    return {pend, tc};
  endfunction
endpackage

// File: rtl/dmac_seq.sv
module dmac_seq
  import dmac_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           mclr,
  input  logic           ff_clr,
  input  logic           ff_set,
  input  logic           ff_tog,
  input  logic           mc_clr,
  input  logic           mc_inc,
  output logic           hi_sel,
  output logic [CHW-1:0] mcnt
);
  always_ff @(posedge clk) begin
    if (rst || mclr)   hi_sel <= 1'b0;
    else if (ff_clr)   hi_sel <= 1'b0;
    else if (ff_set)   hi_sel <= 1'b1;
    else if (ff_tog)   hi_sel <= ~hi_sel;
  end

  always_ff @(posedge clk) begin
    if (rst || mclr || mc_clr) mcnt <= '0;
    else if (mc_inc)           mcnt <= mcnt + 1'b1;
  end

  a_r2_toggle: assert property (@(posedge clk) disable iff (rst)
    (ff_tog && !ff_clr && !ff_set && !mclr) |=> (hi_sel != $past(hi_sel)));
  a_r5_seq_clear: assert property (@(posedge clk) disable iff (rst)
    mclr |=> (!hi_sel && mcnt == '0));
  a_r4_ff_set: assert property (@(posedge clk) disable iff (rst)
    (ff_set && !mclr) |=> hi_sel);
endmodule

// File: rtl/dmac_chan_regs.sv
module dmac_chan_regs
  import dmac_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_pair,
  input  logic [CHW-1:0]          ch,
  input  logic                    is_cnt,
  input  logic                    hi_sel,
  input  logic [DW-1:0]           din,
  output logic [NCH-1:0][RW-1:0]  cur_addr,
  output logic [NCH-1:0][RW-1:0]  cur_cnt
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [RW-1:0] base_addr, base_cnt;
    logic hit;
    assign hit = wr_pair && (ch == CHW'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        base_addr   <= '0;
        base_cnt    <= '0;
        cur_addr[g] <= '0;
        cur_cnt[g]  <= '0;
      end else if (hit) begin
        if (is_cnt) begin
          base_cnt   <= put_byte(base_cnt, hi_sel, din);
          cur_cnt[g] <= put_byte(base_cnt, hi_sel, din);
        end else begin
          base_addr   <= put_byte(base_addr, hi_sel, din);
          cur_addr[g] <= put_byte(base_addr, hi_sel, din);
        end
      end
    end

    a_r3_base_cur_match: assert property (@(posedge clk) disable iff (rst)
      hit |=> (cur_addr[g] == base_addr && cur_cnt[g] == base_cnt));
  end
endmodule

// File: rtl/dmac_ctrl.sv
module dmac_ctrl
  import dmac_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [3:0]             addr,
  input  logic [DW-1:0]          din,
  input  logic [NCH-1:0]         tc_set,
  input  logic [NCH-1:0]         dreq,
  output logic                   mclr,
  output logic [DW-1:0]          cmd_q,
  output logic [NCH-1:0]         mask_q,
  output logic [NCH-1:0]         swreq_q,
  output logic [NCH-1:0]         tc_q,
  output logic [DW-1:0]          status,
  output logic [NCH-1:0][MW-1:0] mode_q
);
  logic cmd_wr, req_wr, smask_wr, mode_wr, cmask_wr, amask_wr, stat_rd;
  logic [CHW-1:0] sel;

  assign mclr     = wr_en && addr == A_MCLR;
  assign cmd_wr   = wr_en && addr == A_CMD;
  assign req_wr   = wr_en && addr == A_REQ;
  assign smask_wr = wr_en && addr == A_SMASK;
  assign mode_wr  = wr_en && addr == A_MODE;
  assign cmask_wr = wr_en && addr == A_CMASK;
  assign amask_wr = wr_en && addr == A_AMASK;
  assign stat_rd  = rd_en && addr == A_CMD;
  assign sel      = din[CHW-1:0];
  assign status   = status_byte(swreq_q | dreq, tc_q);

  always_ff @(posedge clk) begin
    if (rst || mclr) begin
      cmd_q   <= '0;
      mask_q  <= '1;
      swreq_q <= '0;
      tc_q    <= '0;
    end else begin
      if (cmd_wr) cmd_q <= din;
      if (cmask_wr)      mask_q      <= '0;
      else if (amask_wr) mask_q      <= din[NCH-1:0];
      else if (smask_wr) mask_q[sel] <= din[2];
      if (req_wr) swreq_q[sel] <= din[2];
      tc_q <= (stat_rd ? '0 : tc_q) | tc_set;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          mode_q      <= '0;
    else if (mode_wr) mode_q[sel] <= din[DW-1:2];
  end

  a_r5_master_clear: assert property (@(posedge clk) disable iff (rst)
    mclr |=> (mask_q == '1 && cmd_q == '0 && swreq_q == '0 && tc_q == '0));
  a_r6_clear_mask: assert property (@(posedge clk) disable iff (rst)
    cmask_wr |=> (mask_q == '0));
  a_r8_status_clear: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && tc_set == '0) |=> (tc_q == '0));
  a_r8_tc_survives: assert property (@(posedge clk) disable iff (rst)
    (tc_set != '0 && !mclr) |=> ((tc_q & $past(tc_set)) == $past(tc_set)));
endmodule

// File: rtl/dmac_regport.sv
module dmac_regport
  import dmac_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               cs,
  input  logic               wr,
  input  logic               rd,
  input  logic [3:0]         addr,
  input  logic [DW-1:0]      din,
  output logic [DW-1:0]      dout,
  input  logic [NCH-1:0]     tc_set,
  input  logic [NCH-1:0]     dreq,
  output logic [DW-1:0]      cmd_q,
  output logic [NCH-1:0]     mask_q,
  output logic [NCH-1:0]     swreq_q,
  output logic [NCH*MW-1:0]  chan_mode
);
  logic wr_en, rd_en, is_pair, pair_acc, mode_rd, mclr;
  logic hi_sel;
  logic [CHW-1:0] mcnt;
  logic [NCH-1:0][RW-1:0] cur_addr, cur_cnt;
  logic [NCH-1:0][MW-1:0] mode_q;
  logic [NCH-1:0] tc_q;
  logic [DW-1:0] status;

  assign wr_en    = cs && wr;
  assign rd_en    = cs && rd && !wr;
  assign is_pair  = !addr[3];
  assign pair_acc = is_pair && (wr_en || rd_en);
  assign mode_rd  = rd_en && addr == A_MODE;

  dmac_seq u_seq (
    .clk(clk), .rst(rst), .mclr(mclr),
    .ff_clr(wr_en && addr == A_FF), .ff_set(rd_en && addr == A_FF),
    .ff_tog(pair_acc),
    .mc_clr(rd_en && addr == A_CMASK), .mc_inc(mode_rd),
    .hi_sel(hi_sel), .mcnt(mcnt)
  );

  dmac_chan_regs u_regs (
    .clk(clk), .rst(rst), .wr_pair(wr_en && is_pair),
    .ch(addr[2:1]), .is_cnt(addr[0]), .hi_sel(hi_sel), .din(din),
    .cur_addr(cur_addr), .cur_cnt(cur_cnt)
  );

  dmac_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .din(din), .tc_set(tc_set), .dreq(dreq), .mclr(mclr),
    .cmd_q(cmd_q), .mask_q(mask_q), .swreq_q(swreq_q), .tc_q(tc_q),
    .status(status), .mode_q(mode_q)
  );

  assign chan_mode = mode_q;

  always_comb begin
    dout = '0;
    if (rd_en) begin
      if (is_pair)
        dout = get_byte(addr[0] ? cur_cnt[addr[2:1]] : cur_addr[addr[2:1]], hi_sel);
      else if (addr == A_CMD)
        dout = status;
      else if (addr == A_MODE)
        dout = mode_view(mode_q[mcnt]);
    end
  end

  a_r10_mode_lsbs: assert property (@(posedge clk) disable iff (rst)
    mode_rd |-> (dout[1:0] == 2'b11));
  a_r10_mcnt_step: assert property (@(posedge clk) disable iff (rst)
    (mode_rd && !mclr) |=> (mcnt == $past(mcnt) + 1'b1));
  a_r12_idle_dout: assert property (@(posedge clk) disable iff (rst)
    !cs |-> (dout == '0));
endmodule

// File: tb/sim_dmac_regport.sv
module sim_dmac_regport;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst = 1'b1, cs = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic [3:0] tc_set = '0, dreq = '0;
  logic [7:0] cmd_q;
  logic [3:0] mask_q, swreq_q;
  logic [23:0] chan_mode;

  int checks = 0, failures = 0;
  logic [7:0] got;

  always #(CLK_P/2) clk = ~clk;

  dmac_regport u0 (
    .clk(clk), .rst(rst), .cs(cs), .wr(wr), .rd(rd), .addr(addr), .din(din),
    .dout(dout), .tc_set(tc_set), .dreq(dreq), .cmd_q(cmd_q),
    .mask_q(mask_q), .swreq_q(swreq_q), .chan_mode(chan_mode)
  );

  typedef struct packed {
    logic       is_rd;
    logic [3:0] a;
    logic [7:0] d;
    logic [7:0] e;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 4'd12, 8'h00, 8'h00, 4'd4},
    '{1'b0, 4'd0,  8'h34, 8'h00, 4'd2},
    '{1'b0, 4'd0,  8'h12, 8'h00, 4'd2},
    '{1'b1, 4'd0,  8'h00, 8'h34, 4'd3},
    '{1'b1, 4'd0,  8'h00, 8'h12, 4'd2},
    '{1'b0, 4'd3,  8'hCD, 8'h00, 4'd3},
    '{1'b0, 4'd3,  8'hAB, 8'h00, 4'd3},
    '{1'b1, 4'd3,  8'h00, 8'hCD, 4'd3},
    '{1'b1, 4'd3,  8'h00, 8'hAB, 4'd2},
    '{1'b0, 4'd11, 8'h45, 8'h00, 4'd9},
    '{1'b0, 4'd11, 8'h88, 8'h00, 4'd9},
    '{1'b0, 4'd11, 8'hFE, 8'h00, 4'd9},
    '{1'b0, 4'd11, 8'h03, 8'h00, 4'd9},
    '{1'b1, 4'd14, 8'h00, 8'h00, 4'd10},
    '{1'b1, 4'd11, 8'h00, 8'h8B, 4'd10},
    '{1'b1, 4'd11, 8'h00, 8'h47, 4'd10},
    '{1'b1, 4'd11, 8'h00, 8'hFF, 4'd10},
    '{1'b1, 4'd11, 8'h00, 8'h03, 4'd10},
    '{1'b1, 4'd11, 8'h00, 8'h8B, 4'd10},
    '{1'b0, 4'd8,  8'h5A, 8'h00, 4'd11},
    '{1'b0, 4'd9,  8'h06, 8'h00, 4'd7},
    '{1'b1, 4'd8,  8'h00, 8'h40, 4'd8},
    '{1'b1, 4'd9,  8'h00, 8'h00, 4'd12},
    '{1'b1, 4'd15, 8'h00, 8'h00, 4'd12}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; addr = a; din = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr = a;
    #1 v = dout;
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 mask", mask_q, 4'hF);
    chk("R1 cmd", cmd_q, 0);
    chk("R1 swreq", swreq_q, 0);
    chk("R1 modes", chan_mode, 0);
    rd_reg(4'd8, got); chk("R1 status", got, 0);
    rd_reg(4'd0, got); chk("R1 addr low", got, 0);

    // Vector table: R2 R3 R4 R7 R8 R9 R10 R11 R12
    for (int i = 0; i < NV; i++) begin
      if (TBL[i].is_rd) begin
        rd_reg(TBL[i].a, got);
        chk($sformatf("R%0d vec%0d", TBL[i].rq, i), got, TBL[i].e);
      end else begin
        wr_reg(TBL[i].a, TBL[i].d);
      end
    end

    // R11 command, R9 mode output, R7 request output
    chk("R11 cmd out", cmd_q, 8'h5A);
    chk("R9 ch1 mode", chan_mode[11:6], 6'b010001);
    chk("R9 ch2 mode", chan_mode[17:12], 6'b111111);
    chk("R7 swreq set", swreq_q, 4'b0100);

    // R4 pointer clear then set
    wr_reg(4'd12, 8'h00);
    wr_reg(4'd4, 8'h11);
    wr_reg(4'd4, 8'h22);
    rd_reg(4'd12, got); chk("R4 read12 zero", got, 0);
    rd_reg(4'd4, got);  chk("R4 high first", got, 8'h22);
    rd_reg(4'd4, got);  chk("R4 then low", got, 8'h11);

    wr_reg(4'd9, 8'h02); chk("R7 swreq clear", swreq_q, 0);

    // R5 master clear with pointer left on the high byte
    wr_reg(4'd9, 8'h05);
    wr_reg(4'd10, 8'h00); chk("R6 single clear", mask_q, 4'b1110);
    wr_reg(4'd13, 8'h00);
    chk("R5 mask", mask_q, 4'hF);
    chk("R5 cmd", cmd_q, 0);
    chk("R5 swreq", swreq_q, 0);
    rd_reg(4'd0, got);  chk("R5 ptr low, addr kept", got, 8'h34);
    rd_reg(4'd11, got); chk("R5 mcnt cleared, mode kept", got, 8'h8B);

    // R6 mask commands
    wr_reg(4'd14, 8'h00); chk("R6 clear all", mask_q, 0);
    wr_reg(4'd10, 8'h06); chk("R6 single set", mask_q, 4'b0100);
    wr_reg(4'd10, 8'h02); chk("R6 single clr", mask_q, 0);
    wr_reg(4'd15, 8'h09); chk("R6 all write", mask_q, 4'b1001);

    // R8 status
    wr_reg(4'd9, 8'h04);
    dreq = 4'b0010;
    @(negedge clk); tc_set = 4'b0101;
    @(negedge clk); tc_set = 4'b0000;
    rd_reg(4'd8, got); chk("R8 status", got, 8'h35);
    rd_reg(4'd8, got); chk("R8 tc cleared", got, 8'h30);
    tc_set = 4'b1000;
    rd_reg(4'd8, got); chk("R8 tc with read", got, 8'h38);
    tc_set = 4'b0000;
    rd_reg(4'd8, got); chk("R8 tc survived", got, 8'h38);
    rd_reg(4'd8, got); chk("R8 tc cleared again", got, 8'h30);

    // R12 chip select low
    @(negedge clk);
    wr = 1'b1; addr = 4'd8; din = 8'hFF;
    @(negedge clk);
    wr = 1'b0; rd = 1'b1;
    #1 chk("R12 no cs dout", dout, 0);
    @(negedge clk);
    rd = 1'b0;
    chk("R12 no cs cmd", cmd_q, 0);
    rd_reg(4'd13, got); chk("R12 read13", got, 0);
    rd_reg(4'd10, got); chk("R12 read10", got, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule